// File: doc/BRIEF.md
# Dual-Strobe Burst Address Generator

This block sits in front of a synchronous burst memory and produces the word address for each beat of a four-beat burst. A new external address can be loaded through either of two active-low strobes: a processor-side strobe and a controller-side strobe. The processor strobe has priority, but it is vetoed by the first chip enable. Three chip enables are looked at only on a load cycle, and they decide whether the device counts as selected for the burst that follows.

The two lowest address bits give the burst start position. An active-low advance input steps a 2-bit beat count while the device is selected. A static order input maps start and count onto the output's low bits, either as a linear sequence that wraps or as an XOR-interleaved sequence. A one-cycle pulse after every accepted load tells the datapath that a fresh address, and not a continued burst, is on the output.

Control is a two-state machine. ST_DESEL is the reset state. ST_SELECTED is entered from any state by a load with all three enables active. ST_DESEL is entered from any state by a load with any enable inactive. Without a load, the state holds.

Top module: `burst_addr_gen`

## Requirements
- R1: While the synchronous active-high `rst` is high, at the following edge `selected` goes to 0, `load_pulse` to 0 and `addr_out` to 0.
- R2: A processor strobe (`proc_strb_n`=0) with `ce1_n`=0 is an accepted load. From the next edge `addr_out` equals the sampled `addr_in`.
- R3: A controller strobe (`ctrl_strb_n`=0) is an accepted load whatever the level of `ce1_n`, and captures `addr_in` the same way.
- R4: A processor strobe with `ce1_n`=1 and `ctrl_strb_n`=1 is ignored: `addr_out`, `selected` and `load_pulse` behave as if no strobe were present.
- R5: With both strobes low, the processor strobe wins when `ce1_n`=0. When `ce1_n`=1 the controller strobe performs the load, and that load deselects.
- R6: On an accepted load, `selected` becomes 1 if `ce1_n`=0, `ce2`=1 and `ce3_n`=0, and becomes 0 otherwise. On cycles without a load the enables have no effect.
- R7: With `order_sel`=0 (linear), the low two bits of `addr_out` equal (start + count) mod 4, where start is the loaded `addr_in[1:0]`.
- R8: With `order_sel`=1 (interleaved), the low two bits of `addr_out` equal start XOR count.
- R9: After four advances the count wraps and `addr_out` returns to the loaded address. Upper address bits never change during a burst.
- R10: With no accepted load and `adv_n`=1, `addr_out` and `selected` hold their values.
- R11: While `selected`=0, `adv_n`=0 does not change `addr_out`.
- R12: `load_pulse` is 1 for exactly the cycle after each accepted load and 0 otherwise.
- R13: A load in the same cycle as `adv_n`=0 restarts the count at 0, so `addr_out` equals the new `addr_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every input is sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| proc_strb_n | input | 1 | Processor-side address strobe, active low |
| ctrl_strb_n | input | 1 | Controller-side address strobe, active low |
| ce1_n | input | 1 | Chip enable 1, active low; also vetoes the processor strobe |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_sel | input | 1 | Static burst order: 0 linear, 1 interleaved |
| addr_in | input | ADDR_W | External word address |
| addr_out | output | ADDR_W | Current beat address |
| selected | output | 1 | Device selected by the last load |
| load_pulse | output | 1 | High for one cycle after an accepted load |

## Verification
The hardest cases to reach are the ones where both strobes are low and the first enable is high. The processor strobe must be vetoed and the controller strobe must still load, which deselects the device. The bench then advances while deselected to show that the count is frozen. It also changes `ce2` and `ce3_n` on non-load cycles in the middle of a burst to show they are ignored. A stretch of random strobe, enable and advance patterns, run in both burst orders, is compared against a behavioural model on every clock.

// File: rtl/burst_pkg.sv
package burst_pkg;

    typedef enum logic {
        ST_DESEL    = 1'b0,
        ST_SELECTED = 1'b1
    } sel_state_t;

    typedef enum logic {
        ORDER_LINEAR      = 1'b0,
        ORDER_INTERLEAVED = 1'b1
    } burst_order_t;

endpackage

// File: rtl/strobe_arbiter.sv
module strobe_arbiter (
    input  logic proc_strb_n,
    input  logic ctrl_strb_n,
    input  logic ce1_n,
    input  logic ce2,
    input  logic ce3_n,
    output logic load,
    output logic enables_ok
);
    logic proc_accept;
    logic ctrl_accept;

    always_comb begin
        // processor strobe is vetoed by chip enable 1
        proc_accept = !proc_strb_n && !ce1_n;
        // controller strobe only matters when processor strobe is not taken
        ctrl_accept = !ctrl_strb_n && !proc_accept;
        load        = proc_accept || ctrl_accept;
        enables_ok  = !ce1_n && ce2 && !ce3_n;
    end
endmodule

// File: rtl/beat_counter.sv
module beat_counter #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] start_in,
    input  logic             step,
    output logic [CNT_W-1:0] start_q,
    output logic [CNT_W-1:0] count_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            count_q <= '0;
        end else if (load) begin
            start_q <= start_in;
            count_q <= '0;
        end else if (step) begin
            count_q <= count_q + 1'b1;
        end
    end
endmodule

// File: rtl/order_map.sv
module order_map
    import burst_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic             order_sel,
    input  logic [CNT_W-1:0] start,
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] low_bits
);
    logic [CNT_W-1:0] linear_bits;
    logic [CNT_W-1:0] xor_bits;
    burst_order_t     order;

    always_comb begin
        order       = burst_order_t'(order_sel);
        linear_bits = start + count;
        xor_bits    = start ^ count;
        unique case (order)
            ORDER_LINEAR:      low_bits = linear_bits;
            ORDER_INTERLEAVED: low_bits = xor_bits;
            default:           low_bits = linear_bits;
        endcase
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int BURST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              proc_strb_n,
    input  logic              ctrl_strb_n,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              adv_n,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic              selected,
    output logic              load_pulse
);
    localparam int CNT_W = $clog2(BURST_LEN);
    localparam int HI_W  = ADDR_W - CNT_W;

    logic             load;
    logic             enables_ok;
    logic             step;
    sel_state_t       state_q;
    sel_state_t       state_d;
    logic [HI_W-1:0]  base_hi_q;
    logic             pulse_q;
    logic [CNT_W-1:0] start_q;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] low_bits;

    strobe_arbiter u_arb (
        .proc_strb_n (proc_strb_n),
        .ctrl_strb_n (ctrl_strb_n),
        .ce1_n       (ce1_n),
        .ce2         (ce2),
        .ce3_n       (ce3_n),
        .load        (load),
        .enables_ok  (enables_ok)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DESEL:    if (load && enables_ok)  state_d = ST_SELECTED;
            ST_SELECTED: if (load && !enables_ok) state_d = ST_DESEL;
            default:     state_d = ST_DESEL;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_DESEL;
        else     state_q <= state_d;
    end

    // output registers: captured upper address and load pulse
    always_ff @(posedge clk) begin
        if (rst) begin
            base_hi_q <= '0;
            pulse_q   <= 1'b0;
        end else begin
            pulse_q <= load;
            if (load) base_hi_q <= addr_in[ADDR_W-1:CNT_W];
        end
    end

    assign step = !adv_n && (state_q == ST_SELECTED) && !load;

    beat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .start_in (addr_in[CNT_W-1:0]),
        .step     (step),
        .start_q  (start_q),
        .count_q  (count_q)
    );

    order_map #(.CNT_W(CNT_W)) u_map (
        .order_sel (order_sel),
        .start     (start_q),
        .count     (count_q),
        .low_bits  (low_bits)
    );

    assign addr_out   = {base_hi_q, low_bits};
    assign selected   = (state_q == ST_SELECTED);
    assign load_pulse = pulse_q;

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int ADDR_W    = 16,
    parameter int BURST_LEN = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              proc_strb_n,
    input logic              ctrl_strb_n,
    input logic              ce1_n,
    input logic              ce2,
    input logic              ce3_n,
    input logic              adv_n,
    input logic              order_sel,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] addr_out,
    input logic              selected,
    input logic              load_pulse
);
    localparam int CNT_W = $clog2(BURST_LEN);

    logic p_take;
    logic any_take;
    assign p_take   = !proc_strb_n && !ce1_n;
    assign any_take = p_take || !ctrl_strb_n;

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (!selected && !load_pulse && addr_out == '0)); // R1

    AST_PROC_LOAD: assert property (@(posedge clk) disable iff (rst)
        p_take |=> (addr_out == $past(addr_in))); // R2

    AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_strb_n && ce1_n) |=> (addr_out == $past(addr_in) && !selected)); // R5

    AST_PROC_VETO: assert property (@(posedge clk) disable iff (rst)
        (!proc_strb_n && ce1_n && ctrl_strb_n) |=> !load_pulse); // R4

    AST_SELECT_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
        (any_take && !ce1_n && ce2 && !ce3_n) |=> selected); // R6

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (rst)
        (!any_take && !adv_n && selected && !order_sel) |=>
        (addr_out[CNT_W-1:0] == CNT_W'($past(addr_out[CNT_W-1:0]) + 1'b1)
         && addr_out[ADDR_W-1:CNT_W] == $past(addr_out[ADDR_W-1:CNT_W]))); // R7

    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!any_take && adv_n) |=> ($stable(addr_out) && $stable(selected))); // R10

    AST_FROZEN_DESEL: assert property (@(posedge clk) disable iff (rst)
        (!any_take && !selected) |=> ($stable(addr_out) && !selected)); // R11

    AST_PULSE_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
        any_take |=> load_pulse); // R12

    AST_NO_STRAY_PULSE: assert property (@(posedge clk) disable iff (rst)
        !any_take |=> !load_pulse); // R12

endmodule

bind burst_addr_gen burst_addr_gen_chk #(
    .ADDR_W    (ADDR_W),
    .BURST_LEN (BURST_LEN)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .proc_strb_n (proc_strb_n),
    .ctrl_strb_n (ctrl_strb_n),
    .ce1_n       (ce1_n),
    .ce2         (ce2),
    .ce3_n       (ce3_n),
    .adv_n       (adv_n),
    .order_sel   (order_sel),
    .addr_in     (addr_in),
    .addr_out    (addr_out),
    .selected    (selected),
    .load_pulse  (load_pulse)
);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          proc_strb_n = 1'b1;
    logic          ctrl_strb_n = 1'b1;
    logic          ce1_n = 1'b1;
    logic          ce2 = 1'b0;
    logic          ce3_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          order_sel = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;
    logic          selected;
    logic          load_pulse;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // behavioural reference state
    int m_base  = 0;
    int m_start = 0;
    int m_cnt   = 0;
    bit m_sel   = 0;
    bit m_pulse = 0;

    always #5 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW), .BURST_LEN(4)) u_dut (
        .clk (clk), .rst (rst),
        .proc_strb_n (proc_strb_n), .ctrl_strb_n (ctrl_strb_n),
        .ce1_n (ce1_n), .ce2 (ce2), .ce3_n (ce3_n),
        .adv_n (adv_n), .order_sel (order_sel), .addr_in (addr_in),
        .addr_out (addr_out), .selected (selected), .load_pulse (load_pulse)
    );

    function automatic int exp_addr();
        int lo;
        if (order_sel) lo = m_start ^ m_cnt;
        else           lo = (m_start + m_cnt) % 4;
        return (m_base / 4) * 4 + lo;
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // one clock: drive at negedge, predict, compare at next negedge
    task automatic step(string tag, bit rs, bit ps, bit cs, bit c1, bit c2,
                        bit c3, bit adv, int a);
        bit take;
        rst = rs; proc_strb_n = ps; ctrl_strb_n = cs;
        ce1_n = c1; ce2 = c2; ce3_n = c3; adv_n = adv; addr_in = AW'(a);
        if (rs) begin
            m_base = 0; m_start = 0; m_cnt = 0; m_sel = 0; m_pulse = 0;
        end else begin
            take = (!ps && !c1) || !cs;
            m_pulse = take;
            if (take) begin
                m_base  = a % (1 << AW);
                m_start = a % 4;
                m_cnt   = 0;
                m_sel   = !c1 && c2 && !c3;
            end else if (!adv && m_sel) begin
                m_cnt = (m_cnt + 1) % 4;
            end
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, "addr_out", int'(addr_out), exp_addr());
        check(tag, "selected", int'(selected), int'(m_sel));
        check(tag, "load_pulse", int'(load_pulse), int'(m_pulse));
    endtask

    // shorthand helpers
    task automatic idle(string tag);
        step(tag, 0, 1, 1, 1, 0, 1, 1, 16'h0);
    endtask
    task automatic adv1(string tag);
        step(tag, 0, 1, 1, 1, 0, 1, 0, 16'h0);
    endtask
    task automatic pload(string tag, int a);
        step(tag, 0, 0, 1, 0, 1, 0, 1, a);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        step("R1", 1, 1, 1, 1, 0, 1, 1, 16'h0);
        step("R1", 1, 0, 0, 0, 1, 0, 0, 16'hFFFF);
        order_sel = 1'b0;

        // R2 / R7 / R9: processor load, linear burst with wrap
        pload("R2", 16'hA5B6);
        for (int i = 0; i < 5; i++) adv1("R7_R9");
        // R10: hold
        idle("R10"); idle("R10");
        // R4: processor strobe vetoed by ce1_n
        step("R4", 0, 0, 1, 1, 1, 0, 1, 16'h1234);
        // R6: enables wiggle during a burst without load
        step("R6", 0, 1, 1, 1, 0, 1, 0, 16'h5555);
        // R5: both strobes low, ce1_n high -> controller load, deselect
        step("R5", 0, 0, 0, 1, 1, 0, 1, 16'h0F0D);
        // R11: advance while deselected does nothing
        adv1("R11"); adv1("R11");
        // R3: controller load with all enables active
        step("R3", 0, 1, 0, 0, 1, 0, 1, 16'h7771);
        adv1("R3");
        // R6: controller load with ce3_n inactive deselects
        step("R6", 0, 1, 0, 0, 1, 1, 1, 16'h2222);
        step("R6", 0, 1, 0, 0, 0, 0, 1, 16'h3333);
        step("R6", 0, 1, 0, 0, 1, 0, 1, 16'h4443);
        // R5: both strobes low with ce1_n low, processor wins
        step("R5", 0, 0, 0, 0, 1, 0, 1, 16'hBEEF);
        // R13: load coincides with advance
        adv1("R13");
        step("R13", 0, 0, 1, 0, 1, 0, 0, 16'hC0DE);
        adv1("R13");

        // R8: interleaved order, change strap under reset
        step("R1", 1, 1, 1, 1, 0, 1, 1, 16'h0);
        order_sel = 1'b1;
        step("R1", 1, 1, 1, 1, 0, 1, 1, 16'h0);
        pload("R8", 16'h9001);
        for (int i = 0; i < 4; i++) adv1("R8");
        pload("R8", 16'h9003);
        for (int i = 0; i < 5; i++) adv1("R8_R9");
        pload("R8", 16'h9002);
        adv1("R8"); idle("R10"); adv1("R8");

        // R12: random traffic in both orders
        for (int k = 0; k < 2; k++) begin
            step("R1", 1, 1, 1, 1, 0, 1, 1, 16'h0);
            order_sel = k[0];
            step("R1", 1, 1, 1, 1, 0, 1, 1, 16'h0);
            for (int i = 0; i < 150; i++) begin
                int r;
                r = int'($urandom);
                step("R12", 0, r[0] | r[1], r[2] | r[3], r[4] & r[5],
                     r[6] | r[7], r[8] & r[9], r[10], r[31:16]);
            end
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule